// File: doc/BRIEF.md
# Operand-Isolated Two-Function Datapath

This block holds four operand registers that feed two arithmetic functions: a sum of the first pair and the low half of the product of the second pair. A single output register keeps the result of one of the two. The block is built so that its switching activity stays low. An operand pair is captured only when its function is the one selected and only when that capture will actually produce an output update. Logic whose result cannot reach the output therefore sees no change at its inputs.

A capture takes place when `load_op`, `load_out` and the matching value of `sel_in` all hold in the same cycle. The select value is stored with the operands. In the following cycle the output register takes the stored function's result. Once the operands are in their registers, the inputs can change freely without affecting the result in flight.

Top module: `opIsoTop`

## Requirements
- R1: A synchronous active-high `rst` clears all four operand registers and `res_out` to zero. After reset is released, `res_out` reads 0.
- R2: When `load_op`, `load_out` are 1 and `sel_in` is 0 at a rising edge, `res_out` equals `(a_in + b_in) mod 2^W` after the next rising edge.
- R3: When `load_op`, `load_out` are 1 and `sel_in` is 1 at a rising edge, `res_out` equals the low W bits of `c_in * d_in` after the next rising edge.
- R4: `load_op` without `load_out` captures no operands and leaves `res_out` unchanged.
- R5: `load_out` without `load_op` captures no operands and leaves `res_out` unchanged.
- R6: The operand pair of the unselected function keeps its value during a capture. The result depends only on the selected pair.
- R7: `res_out` changes only on the edge that follows a capture. At all other times it holds.
- R8: The select used for the output is the one stored at capture time. Back-to-back captures with alternating select each give their own result one cycle after their capture.
- R9: Both functions wrap to W bits. Carries and high product bits are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | First operand of the sum |
| b_in | input | W | Second operand of the sum |
| c_in | input | W | First operand of the product |
| d_in | input | W | Second operand of the product |
| sel_in | input | 1 | 0 picks the sum, 1 picks the product |
| load_op | input | 1 | Operand capture strobe |
| load_out | input | 1 | Output load strobe; capture needs it too |
| res_out | output | W | Registered result |

## Verification
The sum and the product are each tried with small values and with values that overflow W bits. While one pair is used, the other pair is driven with unrelated values, so that a result leaking from the wrong pair becomes visible. Each strobe is raised alone with fresh operands, which separates a correct three-way enable from one that ignores either strobe. Back-to-back captures with alternating select, and a select that flips right after capture, show whether the stored select steers the output rather than the live input.

// File: rtl/opIsoPkg.sv
package opIsoPkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic capAB;   // load first operand pair
    logic capCD;   // load second operand pair
    logic loadRes; // load output register
    logic selRes;  // 0: sum, 1: product
  } strobes_t;
endpackage

// File: rtl/opIsoCtrl.sv
module opIsoCtrl
  import opIsoPkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     selIn,
  input  logic     loadOp,
  input  logic     loadOut,
  output strobes_t stb
);
  logic capAny;
  logic pendQ;
  logic selQ;

  // Capture only when an output load will consume the result
  assign capAny = loadOp & loadOut;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendQ <= 1'b0;
      selQ  <= 1'b0;
    end else begin
      pendQ <= capAny;
      if (capAny) selQ <= selIn;
    end
  end

  always_comb begin
    stb.capAB   = capAny & ~selIn;
    stb.capCD   = capAny & selIn;
    stb.loadRes = pendQ;
    stb.selRes  = selQ;
  end
endmodule

// File: rtl/opIsoDatapath.sv
module opIsoDatapath
  import opIsoPkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  strobes_t     stb,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic [W-1:0] cIn,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] opA,
  output logic [W-1:0] opB,
  output logic [W-1:0] opC,
  output logic [W-1:0] opD,
  output logic [W-1:0] resQ
);
  localparam int NOPS = 4;

  logic [W-1:0] inVec  [NOPS];
  logic [W-1:0] regVec [NOPS];
  logic [NOPS-1:0] enVec;
  logic [W-1:0] sumW;
  logic [W-1:0] prodW;

  assign inVec[0] = aIn;
  assign inVec[1] = bIn;
  assign inVec[2] = cIn;
  assign inVec[3] = dIn;
  assign enVec    = {stb.capCD, stb.capCD, stb.capAB, stb.capAB};

  // One enabled register per operand; disabled ones never toggle
  for (genvar i = 0; i < NOPS; i++) begin : g_opReg
    always_ff @(posedge clk) begin
      if (rst)           regVec[i] <= '0;
      else if (enVec[i]) regVec[i] <= inVec[i];
    end
  end

  assign opA = regVec[0];
  assign opB = regVec[1];
  assign opC = regVec[2];
  assign opD = regVec[3];

  // Both functions truncate to W bits
  assign sumW  = opA + opB;
  assign prodW = opC * opD;

  always_ff @(posedge clk) begin
    if (rst)              resQ <= '0;
    else if (stb.loadRes) resQ <= stb.selRes ? prodW : sumW;
  end
endmodule

// File: rtl/opIsoTop.sv
module opIsoTop
  import opIsoPkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] c_in,
  input  logic [W-1:0] d_in,
  input  logic         sel_in,
  input  logic         load_op,
  input  logic         load_out,
  output logic [W-1:0] res_out
);
  strobes_t     stb;
  logic [W-1:0] opA, opB, opC, opD;

  opIsoCtrl u_ctrl (
    .clk(clk), .rst(rst), .selIn(sel_in),
    .loadOp(load_op), .loadOut(load_out), .stb(stb)
  );

  opIsoDatapath #(.W(W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb),
    .aIn(a_in), .bIn(b_in), .cIn(c_in), .dIn(d_in),
    .opA(opA), .opB(opB), .opC(opC), .opD(opD),
    .resQ(res_out)
  );
endmodule

// File: rtl/opIsoChk.sv
module opIsoChk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] c_in,
  input logic [W-1:0] d_in,
  input logic         sel_in,
  input logic         load_op,
  input logic         load_out,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic [W-1:0] opC,
  input logic [W-1:0] opD,
  input logic [W-1:0] res_out
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (res_out == '0 && opA == '0 && opB == '0 && opC == '0 && opD == '0));

  // R2
  sum_result_chk: assert property (@(posedge clk) disable iff (rst)
    (load_op && load_out && !sel_in) |=> ##1 (res_out == $past(a_in, 2) + $past(b_in, 2)));

  // R3
  prod_result_chk: assert property (@(posedge clk) disable iff (rst)
    (load_op && load_out && sel_in) |=> ##1 (res_out == $past(c_in, 2) * $past(d_in, 2)));

  // R4 R5 R6: first pair frozen unless it is the captured one
  ab_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(load_op && load_out && !sel_in) |=> ($stable(opA) && $stable(opB)));

  // R4 R5 R6: second pair frozen unless it is the captured one
  cd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(load_op && load_out && sel_in) |=> ($stable(opC) && $stable(opD)));

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(load_op && load_out) |=> ##1 $stable(res_out));
endmodule

bind opIsoTop opIsoChk #(.W(W)) u_chk (
  .clk(clk), .rst(rst),
  .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in),
  .sel_in(sel_in), .load_op(load_op), .load_out(load_out),
  .opA(opA), .opB(opB), .opC(opC), .opD(opD),
  .res_out(res_out)
);

// File: tb/tb_opIsoTop.sv
module tb_opIsoTop;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in, b_in, c_in, d_in;
  logic         sel_in, load_op, load_out;
  logic [W-1:0] res_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  opIsoTop #(.W(W)) dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in),
    .sel_in(sel_in), .load_op(load_op), .load_out(load_out), .res_out(res_out)
  );

  function automatic logic [W-1:0] sumOf(logic [W-1:0] x, logic [W-1:0] y);
    return x + y;
  endfunction

  function automatic logic [W-1:0] prodOf(logic [W-1:0] x, logic [W-1:0] y);
    return x * y;
  endfunction

  task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic idle();
    load_op = 1'b0; load_out = 1'b0;
  endtask

  // Drive one capture at a negedge; result appears after the second rising edge
  task automatic capture(logic s, logic [W-1:0] a, logic [W-1:0] b,
                         logic [W-1:0] c, logic [W-1:0] d);
    @(negedge clk);
    sel_in = s; a_in = a; b_in = b; c_in = c; d_in = d;
    load_op = 1'b1; load_out = 1'b1;
    @(negedge clk);
    idle();
    sel_in = ~s; a_in = ~a; b_in = ~b; c_in = ~c; d_in = ~d;
    @(negedge clk);
  endtask

  task automatic testReset();
    rst = 1'b1; idle(); sel_in = 0; a_in = 0; b_in = 0; c_in = 0; d_in = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset output", res_out, '0);
  endtask

  task automatic testSum();
    capture(1'b0, 8'd12, 8'd30, 8'd7, 8'd9);
    check("R2 sum small", res_out, sumOf(8'd12, 8'd30));
    capture(1'b0, 8'd200, 8'd100, 8'd3, 8'd5);
    check("R9 sum wrap", res_out, 8'd44);
  endtask

  task automatic testProd();
    capture(1'b1, 8'd77, 8'd99, 8'd6, 8'd7);
    check("R3 product small", res_out, 8'd42);
    capture(1'b1, 8'd1, 8'd2, 8'hF0, 8'h13);
    check("R9 product low half", res_out, 8'd208);
  endtask

  task automatic testIsolation();
    // R6: other pair carries values that would give a different result
    capture(1'b0, 8'd5, 8'd6, 8'd100, 8'd100);
    check("R6 sum ignores second pair", res_out, 8'd11);
    capture(1'b1, 8'd250, 8'd250, 8'd3, 8'd4);
    check("R6 product ignores first pair", res_out, 8'd12);
  endtask

  task automatic testStrobeAlone();
    logic [W-1:0] held;
    capture(1'b0, 8'd40, 8'd2, 8'd0, 8'd0);
    held = res_out;
    check("R2 setup value", held, 8'd42);
    // R4: load_op alone, both selects
    @(negedge clk);
    a_in = 8'd1; b_in = 8'd1; c_in = 8'd9; d_in = 8'd9;
    load_op = 1'b1; load_out = 1'b0; sel_in = 1'b0;
    @(negedge clk); sel_in = 1'b1;
    @(negedge clk); idle();
    @(negedge clk);
    check("R4 load_op alone holds output", res_out, held);
    // R5: load_out alone
    load_out = 1'b1; load_op = 1'b0; sel_in = 1'b1;
    @(negedge clk); sel_in = 1'b0;
    @(negedge clk); idle();
    @(negedge clk);
    check("R5 load_out alone holds output", res_out, held);
    // R7: long idle
    repeat (5) @(negedge clk);
    check("R7 output holds while idle", res_out, held);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    sel_in = 1'b0; a_in = 8'd10; b_in = 8'd20; c_in = 8'd0; d_in = 8'd0;
    load_op = 1'b1; load_out = 1'b1;
    @(negedge clk);
    sel_in = 1'b1; a_in = 8'd0; b_in = 8'd0; c_in = 8'd11; d_in = 8'd11;
    @(negedge clk);
    check("R8 first of pair", res_out, 8'd30);
    idle(); sel_in = 1'b0;
    @(negedge clk);
    check("R8 second of pair", res_out, 8'd121);
    // Select flips after capture; the stored select must steer
    capture(1'b1, 8'd1, 8'd1, 8'd5, 8'd5);
    check("R8 stored select used", res_out, 8'd25);
  endtask

  initial begin
    testReset();
    testSum();
    testProd();
    testIsolation();
    testStrobeAlone();
    testBackToBack();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule